// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Port

This block is a serial transmit and receive port for codec-style links. A host loads parallel words into an output buffer. The port moves each word into a shift register and sends it on a serial data line. The port generates the bit clock and a frame sync pulse itself. The receive side samples a frame-sync input and a data input on the same internal bit clock. It collects a word and presents it in an input buffer.

Two flags let the host service the port by polling or by interrupt: output-buffer-empty and input-buffer-full. Both directions hold one word in a buffer while a second word shifts, so frames can run back to back. An 11-bit control register sets four things: the bit-clock rate (four choices), the bit order, the word length (8 or 16 bits) and a multiprocessor mode. In that mode, up to eight devices share one link. Each frame carries a 3-bit destination address, and a device keeps only the frames addressed to it. The control register also holds the device's own address and the destination address it transmits.

Top module: `sio_port`

## Requirements
- R1: After reset, obe=1, ibf=0, sfs_o=0 and sdo=0. The control register resets to zero, which selects a divide-by-2 bit clock, MSB-first order, 8-bit words and no address mode.
- R2: The control field ctl[1:0]=r sets the bit period to 2^(r+1) system clocks. sclk_o is low in the first half of each bit period and high in the second half. sdo and sfs_o change only at the start of a bit period.
- R3: A frame begins only when the output buffer holds a word. The frame is one bit period with sfs_o=1, then the optional 3 address bits (MSB first), then the data bits, with sfs_o=0 during all of these.
- R4: Control bit ctl[2] selects the bit order for both transmit and receive: 0 sends and receives the most significant data bit first, 1 the least significant bit first.
- R5: Control bit ctl[3] selects the word length: 1 gives 16-bit words, 0 gives 8-bit words. In 8-bit mode the port sends tx_wdata[7:0] and returns the received byte in rx_rdata[7:0], with rx_rdata[15:8]=0.
- R6: A write with tx_we clears obe on the next clock. obe sets again on the clock where the word moves into the shift register, which is the same clock where sfs_o rises.
- R7: If the output buffer is full when the last data bit of a frame ends, the next frame's sync period follows at once with no idle bit.
- R8: The receiver waits for rx_fs=1 at the end of a bit period, then takes the next frame-length bits, one at the end of each period. It then places the word on rx_rdata and sets ibf. A newer word overwrites an unread one. A pulse on rx_re clears ibf.
- R9: When ctl[4]=1, the transmitter sends ctl[10:8] as the address. The receiver accepts a frame only when the received address equals ctl[7:5]. For any other address, ibf and rx_rdata are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 11 | Control value: {dest addr, own addr, mp, wide, lsb_first, rate} |
| tx_we | input | 1 | Output buffer write strobe |
| tx_wdata | input | 16 | Word to transmit |
| obe | output | 1 | Output buffer empty flag |
| rx_re | input | 1 | Input buffer read strobe, clears ibf |
| rx_rdata | output | 16 | Last accepted received word |
| ibf | output | 1 | Input buffer full flag |
| sclk_o | output | 1 | Serial bit clock |
| sfs_o | output | 1 | Transmit frame sync |
| sdo | output | 1 | Serial data out |
| rx_fs | input | 1 | Receive frame sync |
| rx_d | input | 1 | Serial data in |

## Verification
The serial line is looped back to the receive inputs. An independent monitor decodes each frame at the rising bit clock, using the stated bit positions. It would expose a reversed bit order that a plain loopback would hide, because a loopback reverses the bits twice and still looks correct. Words written as soon as obe rises must leave no idle bit between frames. A design that reloads late would break R7. A second word must overwrite an unread first one. A mismatched address must leave ibf and rx_rdata untouched. A design that filters the address badly would raise ibf for a foreign frame. The test also checks that obe rises on the same clock as the sync pulse, and that the bit period is correct at all four rates.

// File: rtl/sio_port.sv
module sio_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [10:0] ctl_wdata,
  input  logic        tx_we,
  input  logic [15:0] tx_wdata,
  output logic        obe,
  input  logic        rx_re,
  output logic [15:0] rx_rdata,
  output logic        ibf,
  output logic        sclk_o,
  output logic        sfs_o,
  output logic        sdo,
  input  logic        rx_fs,
  input  logic        rx_d
);

  function automatic logic [15:0] rev16(input logic [15:0] v);
    for (int i = 0; i < 16; i++) rev16[i] = v[15-i];
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  logic [10:0] ctl;
  logic [3:0]  div_cnt;
  logic        tick;
  logic [4:0]  len;

  wire [1:0] rate  = ctl[1:0];
  wire       lsb   = ctl[2];
  wire       wide  = ctl[3];
  wire       mp    = ctl[4];
  wire [2:0] own   = ctl[7:5];
  wire [2:0] dest  = ctl[10:8];

  assign tick   = {1'b0, div_cnt} >= ((5'd2 << rate) - 5'd1);
  assign sclk_o = {1'b0, div_cnt} >= (5'd1 << rate);
  assign len    = (wide ? 5'd16 : 5'd8) + (mp ? 5'd3 : 5'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl <= '0;
    else if (ctl_we) ctl <= ctl_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else div_cnt <= tick ? 4'd0 : div_cnt + 4'd1;

  // transmit
  logic [15:0] obuf, tx_ord;
  logic [18:0] tx_sh;
  logic [4:0]  tx_bits;

  always_comb
    if (wide) tx_ord = lsb ? rev16(obuf) : obuf;
    else      tx_ord = {lsb ? rev8(obuf[7:0]) : obuf[7:0], 8'h00};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      obe <= 1'b1; obuf <= '0; tx_sh <= '0; tx_bits <= '0;
      sfs_o <= 1'b0; sdo <= 1'b0;
    end else begin
      if (tx_we) obuf <= tx_wdata;
      if (tx_we) obe <= 1'b0;
      else if (tick && tx_bits == 5'd0 && !obe) obe <= 1'b1;
      if (tick) begin
        if (tx_bits != 5'd0) begin
          sfs_o   <= 1'b0;
          sdo     <= tx_sh[18];
          tx_sh   <= {tx_sh[17:0], 1'b0};
          tx_bits <= tx_bits - 5'd1;
        end else if (!obe) begin
          sfs_o   <= 1'b1;
          sdo     <= 1'b0;
          tx_bits <= len;
          tx_sh   <= mp ? {dest, tx_ord} : {tx_ord, 3'b000};
        end else begin
          sfs_o <= 1'b0;
          sdo   <= 1'b0;
        end
      end
    end

  // receive
  logic [18:0] rx_sh, rx_full;
  logic [4:0]  rx_bits;
  logic [15:0] rx_word;
  logic [2:0]  rx_addr;
  logic        rx_done, rx_take;

  assign rx_full = {rx_sh[17:0], rx_d};
  assign rx_addr = wide ? rx_full[18:16] : rx_full[10:8];
  assign rx_done = tick && rx_bits == 5'd1;
  assign rx_take = rx_done && (!mp || rx_addr == own);

  always_comb
    if (wide) rx_word = lsb ? rev16(rx_full[15:0]) : rx_full[15:0];
    else      rx_word = {8'h00, lsb ? rev8(rx_full[7:0]) : rx_full[7:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sh <= '0; rx_bits <= '0; rx_rdata <= '0; ibf <= 1'b0;
    end else begin
      if (tick) begin
        if (rx_bits != 5'd0) begin
          rx_sh   <= rx_full;
          rx_bits <= rx_bits - 5'd1;
        end else if (rx_fs) begin
          rx_bits <= len;
        end
      end
      if (rx_take) begin
        rx_rdata <= rx_word;
        ibf      <= 1'b1;
      end else if (rx_re) begin
        ibf <= 1'b0;
      end
    end

  a_r6_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_we |=> !obe);
  a_r6_empty_with_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sfs_o) && !$past(tx_we) |-> obe);
  a_r3_sync_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    sfs_o && tick |=> !sfs_o);
  a_r2_hold_within_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sdo) && $stable(sfs_o));
  a_r8_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_re && !tick |=> !ibf);
  a_r9_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && mp && rx_addr != own |=> $stable(rx_rdata));

endmodule

// File: tb/sio_port_tb.sv
module sio_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [10:0] ctl_wdata = '0;
  logic tx_we = 1'b0;
  logic [15:0] tx_wdata = '0;
  logic rx_re = 1'b0;
  logic obe, ibf, sclk_o, sfs_o, sdo;
  logic [15:0] rx_rdata;

  always #2 clk = ~clk;

  sio_port dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .tx_we(tx_we), .tx_wdata(tx_wdata), .obe(obe), .rx_re(rx_re),
    .rx_rdata(rx_rdata), .ibf(ibf), .sclk_o(sclk_o), .sfs_o(sfs_o),
    .sdo(sdo), .rx_fs(sfs_o), .rx_d(sdo)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  bit rd_en = 1;
  logic [15:0] tx_exp_q[$];
  logic [15:0] rx_exp_q[$];

  logic [1:0] m_rate = 0;
  bit m_lsb = 0, m_wide = 0, m_mp = 0;
  logic [2:0] m_own = 0, m_dest = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] wmask(input logic [15:0] w, input bit wide);
    return wide ? w : {8'h00, w[7:0]};
  endfunction

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      report();
    end
  end

  // serial monitor
  bit sclk_prev = 0, last_end = 0;
  int since_rise = 0, last_period = 0, mon_left = 0, mon_k = 0, b2b = 0;
  logic [15:0] mon_word;
  logic [2:0] mon_addr;

  always @(negedge clk) begin
    if (rst_n) begin
      since_rise++;
      if (sclk_o && !sclk_prev) begin
        last_period = since_rise;
        since_rise = 0;
        if (mon_left == 0) begin
          if (sfs_o) begin
            if (last_end) b2b++;
            mon_left = (m_mp ? 3 : 0) + (m_wide ? 16 : 8);
            mon_k = 0; mon_word = '0; mon_addr = '0;
          end
          last_end = 0;
        end else begin
          check(!sfs_o, "R3 sync low in body", sfs_o, 0);
          if (m_mp && mon_k < 3) mon_addr = {mon_addr[1:0], sdo};
          else begin
            int idx, n;
            n = m_wide ? 16 : 8;
            idx = mon_k - (m_mp ? 3 : 0);
            mon_word[m_lsb ? idx : n - 1 - idx] = sdo;
          end
          mon_k++;
          mon_left--;
          if (mon_left == 0) begin
            logic [15:0] e;
            last_end = 1;
            e = tx_exp_q.size() ? tx_exp_q.pop_front() : 16'hdead;
            check(mon_word == e, "R4 R5 serial word", mon_word, e);
            if (m_mp) check(mon_addr == m_dest, "R9 sent address", mon_addr, m_dest);
          end
        end
      end
      sclk_prev = sclk_o;
    end
  end

  // host reader
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_re) begin
        rx_re = 0;
        check(!ibf, "R8 read clears ibf", ibf, 0);
      end else if (rd_en && ibf) begin
        logic [15:0] e;
        check(rx_exp_q.size() != 0, "R9 unexpected word", rx_rdata, 0);
        e = rx_exp_q.size() ? rx_exp_q.pop_front() : 16'h0;
        check(rx_rdata == e, "R8 received word", rx_rdata, e);
        rx_re = 1;
      end
    end
  end

  task automatic set_ctl(input logic [1:0] r, input bit l, input bit w, input bit mp,
                         input logic [2:0] own, input logic [2:0] dest);
    m_rate = r; m_lsb = l; m_wide = w; m_mp = mp; m_own = own; m_dest = dest;
    ctl_wdata = {dest, own, mp, w, l, r};
    ctl_we = 1;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic send(input logic [15:0] w, input bit push_rx);
    while (!obe) @(negedge clk);
    tx_wdata = w;
    tx_we = 1;
    tx_exp_q.push_back(wmask(w, m_wide));
    if (push_rx && (!m_mp || m_dest == m_own)) rx_exp_q.push_back(wmask(w, m_wide));
    @(negedge clk);
    tx_we = 0;
  endtask

  task automatic drain();
    while (tx_exp_q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic run_case(input int n);
    for (int i = 0; i < n; i++) send(16'($urandom), 1);
    drain();
    check(rx_exp_q.size() == 0, "R8 all words received", rx_exp_q.size(), 0);
    check(last_period == (2 << m_rate), "R2 bit period", last_period, 2 << m_rate);
  endtask

  initial begin
    void'($urandom(32'd1627));
    repeat (3) @(negedge clk);
    check(obe == 1, "R1 obe reset", obe, 1);
    check(ibf == 0, "R1 ibf reset", ibf, 0);
    check(sfs_o == 0 && sdo == 0, "R1 serial reset", {sfs_o, sdo}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R6 and R1 defaults
    tx_wdata = 16'h12a5; tx_we = 1;
    tx_exp_q.push_back(16'h00a5); rx_exp_q.push_back(16'h00a5);
    @(negedge clk);
    tx_we = 0;
    check(obe == 0, "R6 write clears obe", obe, 0);
    while (!obe) @(negedge clk);
    check(sfs_o == 1, "R6 obe sets with sync", sfs_o, 1);
    drain();
    check(rx_exp_q.size() == 0, "R1 default frame received", rx_exp_q.size(), 0);
    check(last_period == 2, "R1 R2 default period", last_period, 2);

    // directed orders and lengths
    set_ctl(2'd1, 1, 1, 0, 0, 0); run_case(2);
    set_ctl(2'd2, 1, 0, 0, 0, 0); run_case(2);
    set_ctl(2'd3, 0, 1, 0, 0, 0); run_case(2);

    // R7 back to back
    set_ctl(2'd0, 0, 0, 0, 0, 0);
    begin
      int b0;
      b0 = b2b;
      run_case(4);
      check(b2b - b0 == 3, "R7 back to back frames", b2b - b0, 3);
    end

    // R9 match and mismatch
    set_ctl(2'd1, 0, 1, 1, 3'd5, 3'd5); run_case(2);
    begin
      logic [15:0] keep;
      keep = rx_rdata;
      set_ctl(2'd0, 1, 0, 1, 3'd2, 3'd6); run_case(2);
      check(ibf == 0, "R9 foreign frame ibf", ibf, 0);
      check(rx_rdata == keep, "R9 foreign frame data", rx_rdata, keep);
    end

    // R8 overwrite
    set_ctl(2'd0, 0, 1, 0, 0, 0);
    rd_en = 0;
    send(16'h1111, 0);
    send(16'hbeef, 0);
    drain();
    check(ibf == 1, "R8 ibf held", ibf, 1);
    check(rx_rdata == 16'hbeef, "R8 newest overwrites", rx_rdata, 16'hbeef);
    rx_exp_q.push_back(16'hbeef);
    rd_en = 1;
    repeat (4) @(negedge clk);
    check(rx_exp_q.size() == 0, "R8 overwrite read", rx_exp_q.size(), 0);

    // random configurations
    for (int c = 0; c < 8; c++) begin
      logic [2:0] own, dest;
      own = 3'($urandom);
      dest = ($urandom % 2) ? own : 3'($urandom);
      set_ctl(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), own, dest);
      run_case(3);
    end

    report();
  end
endmodule